// File: doc/BRIEF.md
# Serial Register Port with Staged Commit

This block lets an external host reach a small register file over a four-signal serial link (clock, active-low select, data in, data out). Every access starts with a 16-bit command word that holds the direction, the number of data bytes and the starting address. One to three data bytes follow, most significant bit first. Each byte after the first goes to the next lower address, so a multi-byte register is reached through the address of its top byte.

Writes to the general register window go into a staging copy and do not affect the parallel outputs. A write of 1 to the bit-0 position of the commit register (0x234) moves the whole staging copy into the active copy in one step, so several fields change together. A readback selector chooses which copy reads return. A configuration register moves read data between the shared data pin (3-wire) and a separate output pin (4-wire), and it can issue a soft reset. Two read-only bytes show live status inputs. All serial inputs are synchronised into the system clock domain. The serial clock must therefore run well below the system clock: each half period needs at least four system cycles.

Top module: `spi_shadow_regport`

## Requirements
- R1: The command word is 16 bits, sent MSB first. Bit 15 = 1 means read and 0 means write. Bits 14:13 hold the byte count minus one, and the value 3 is taken as three bytes. Bits 11:0 give the start address, and bit 12 is ignored.
- R2: Data bytes are sampled on rising serial-clock edges and read bits are driven after falling edges, MSB first. The k-th data byte (k = 0, 1, 2) of a transfer uses start address minus k.
- R3: A write into the window REG_BASE..REG_BASE+NUM_REGS-1 changes only the staging copy. `act_regs_o` (byte i at bits 8i+7:8i, for address REG_BASE+i) does not change.
- R4: Writing a byte with bit 0 = 1 to address 0x234 copies all staged bytes to `act_regs_o` within a few system cycles. The commit bit clears itself and reads back as 0.
- R5: Bit 0 of address 0x004 selects the copy that window reads return: 1 returns the staging copy, 0 returns the active copy. The reset value is 0.
- R6: Bit 7 of address 0x000 selects the read pin. When it is 1, data goes out on `sdo_o` with `sdo_oe_o` high. When it is 0, data goes out on `sdio_o` with `sdio_oe_o` high. The two enables are never high together.
- R7: After hardware reset, and after writing a byte with bit 5 = 1 to address 0x000, both copies hold REG_INIT and addresses 0x000 and 0x004 read 0x00.
- R8: Addresses 0x22C and 0x22D return the live values of `stat0_i` and `stat1_i`. Writes to them have no effect.
- R9: Data bytes clocked after the byte count is used up are not written, and no pin is driven for them.
- R10: Raising `cs_n_i` ends the transfer. A partly shifted byte is discarded, and the next transfer starts again with a command word. Neither output enable is high while `cs_n_i` is high.
- R11: A read of an address outside the window and outside the control and status addresses returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idles low |
| cs_n_i | input | 1 | Active-low transfer select |
| sdio_i | input | 1 | Serial data from the host (shared pin input) |
| sdio_o | output | 1 | Read data for the shared pin |
| sdio_oe_o | output | 1 | Drive enable for the shared pin (3-wire reads) |
| sdo_o | output | 1 | Read data for the separate output pin |
| sdo_oe_o | output | 1 | Drive enable for the separate output pin (4-wire reads) |
| stat0_i | input | 8 | Live status byte shown at 0x22C |
| stat1_i | input | 8 | Live status byte shown at 0x22D |
| act_regs_o | output | 8*NUM_REGS | Active copy of the register window |

## Verification
The bench goes after the staging boundary. It checks that a design which leaked writes to the outputs early would show changed `act_regs_o` before any commit, and that one which ignored the readback selector would return the active value where the staged one was expected. It walks descending multi-byte writes across the window edges, sends a byte-count field of 3, clocks extra bytes past the count, and drops the select halfway through a byte. A design that counted up, trusted the extra bytes or kept half a byte would corrupt a neighbouring register. It also toggles the read pin between 3-wire and 4-wire modes and issues a soft reset after committed changes, which shows any enable left on the wrong pin or any copy not returned to its defaults.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] CFG_ADDR   = 12'h000;
    localparam logic [ADDR_W-1:0] RBK_ADDR   = 12'h004;
    localparam logic [ADDR_W-1:0] STAT0_ADDR = 12'h22C;
    localparam logic [ADDR_W-1:0] STAT1_ADDR = 12'h22D;
    localparam logic [ADDR_W-1:0] UPD_ADDR   = 12'h234;

    typedef enum logic {PH_CMD, PH_DATA} phase_e;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } wr_req_t;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spireg_bank.sv
module spireg_bank
    import spireg_pkg::*;
#(
    parameter int                      NUM_REGS = 8,
    parameter logic [ADDR_W-1:0]       REG_BASE = 12'h010,
    parameter logic [NUM_REGS*8-1:0]   REG_INIT = {NUM_REGS{8'hA5}}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  wr_req_t               wr_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    input  logic [7:0]            stat0_i,
    input  logic [7:0]            stat1_i,
    output logic [7:0]            rd_data_o,
    output logic                  sdo_en_o,
    output logic                  upd_pend_o,
    output logic [NUM_REGS*8-1:0] act_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W-1:0] WIN_HI = REG_BASE + ADDR_W'(NUM_REGS - 1);

    typedef struct packed {
        logic [NUM_REGS-1:0][7:0] stg;
        logic [NUM_REGS-1:0][7:0] act;
        logic                     sdo_en;
        logic                     rb_stg;
        logic                     upd_pend;
    } bank_t;

    localparam bank_t BANK_RST = '{stg: REG_INIT, act: REG_INIT,
                                   sdo_en: 1'b0, rb_stg: 1'b0, upd_pend: 1'b0};

    bank_t b_d, b_q;
    logic  wr_in_win, rd_in_win;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    always_comb begin
        wr_in_win = (wr_i.addr >= REG_BASE) && (wr_i.addr <= WIN_HI);
        rd_in_win = (rd_addr_i >= REG_BASE) && (rd_addr_i <= WIN_HI);
        wr_idx    = IDX_W'(wr_i.addr - REG_BASE);
        rd_idx    = IDX_W'(rd_addr_i - REG_BASE);
    end

    always_comb begin
        b_d = b_q;
        if (b_q.upd_pend) begin
            b_d.act      = b_q.stg;
            b_d.upd_pend = 1'b0;
        end
        if (wr_i.vld) begin
            if (wr_i.addr == CFG_ADDR) begin
                if (wr_i.data[5]) b_d = BANK_RST;
                else              b_d.sdo_en = wr_i.data[7];
            end else if (wr_i.addr == RBK_ADDR) begin
                b_d.rb_stg = wr_i.data[0];
            end else if (wr_i.addr == UPD_ADDR) begin
                b_d.upd_pend = wr_i.data[0];
            end else if (wr_in_win) begin
                b_d.stg[wr_idx] = wr_i.data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= BANK_RST;
        else        b_q <= b_d;
    end

    always_comb begin
        rd_data_o = 8'h00;
        if (rd_addr_i == CFG_ADDR)        rd_data_o = {b_q.sdo_en, 7'b0};
        else if (rd_addr_i == RBK_ADDR)   rd_data_o = {7'b0, b_q.rb_stg};
        else if (rd_addr_i == STAT0_ADDR) rd_data_o = stat0_i;
        else if (rd_addr_i == STAT1_ADDR) rd_data_o = stat1_i;
        else if (rd_addr_i == UPD_ADDR)   rd_data_o = {7'b0, b_q.upd_pend};
        else if (rd_in_win)               rd_data_o = b_q.rb_stg ? b_q.stg[rd_idx] : b_q.act[rd_idx];
    end

    assign sdo_en_o   = b_q.sdo_en;
    assign upd_pend_o = b_q.upd_pend;
    assign act_o      = b_q.act;
endmodule

// File: rtl/spi_shadow_regport.sv
module spi_shadow_regport
    import spireg_pkg::*;
#(
    parameter int                    NUM_REGS = 8,
    parameter logic [ADDR_W-1:0]     REG_BASE = 12'h010,
    parameter logic [NUM_REGS*8-1:0] REG_INIT = {NUM_REGS{8'hA5}},
    parameter int                    SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_i,
    input  logic                  cs_n_i,
    input  logic                  sdio_i,
    output logic                  sdio_o,
    output logic                  sdio_oe_o,
    output logic                  sdo_o,
    output logic                  sdo_oe_o,
    input  logic [7:0]            stat0_i,
    input  logic [7:0]            stat1_i,
    output logic [NUM_REGS*8-1:0] act_regs_o
);
    typedef struct packed {
        phase_e            ph;
        logic [3:0]        bitcnt;
        logic [14:0]       sh;
        logic              rd;
        logic [1:0]        lim;
        logic [1:0]        idx;
        logic              live;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        tx;
        logic              dout;
        logic              oe;
        logic              sclk_prev;
        wr_req_t           wr;
    } eng_t;

    eng_t e_d, e_q;

    logic              sclk_s, cs_n_s, mosi_s;
    logic [15:0]       word;
    logic [ADDR_W-1:0] look_addr;
    logic [7:0]        rd_data;
    logic              sdo_en;
    logic              upd_pend;
    wr_req_t           wr_req;
    logic              unused_cmd_bit;
    logic              rise, fall;

    spireg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sclk_i, cs_n_i, sdio_i}),
        .q_o   ({sclk_s, cs_n_s, mosi_s})
    );

    assign word           = {e_q.sh, mosi_s};
    assign unused_cmd_bit = word[12];
    assign look_addr      = (e_q.ph == PH_CMD) ? word[11:0] : e_q.addr - 12'd1;
    assign rise           = sclk_s & ~e_q.sclk_prev;
    assign fall           = ~sclk_s & e_q.sclk_prev;

    always_comb begin
        e_d           = e_q;
        e_d.wr.vld    = 1'b0;
        e_d.sclk_prev = sclk_s;
        if (cs_n_s) begin
            e_d.ph     = PH_CMD;
            e_d.bitcnt = '0;
            e_d.oe     = 1'b0;
            e_d.live   = 1'b0;
        end else if (rise) begin
            e_d.sh = word[14:0];
            if (e_q.ph == PH_CMD) begin
                if (e_q.bitcnt == 4'd15) begin
                    e_d.ph     = PH_DATA;
                    e_d.bitcnt = '0;
                    e_d.rd     = word[15];
                    e_d.lim    = (word[14:13] == 2'b11) ? 2'd2 : word[14:13];
                    e_d.addr   = word[11:0];
                    e_d.idx    = '0;
                    e_d.live   = 1'b1;
                    e_d.tx     = word[15] ? rd_data : 8'h00;
                    e_d.oe     = word[15];
                end else begin
                    e_d.bitcnt = e_q.bitcnt + 4'd1;
                end
            end else if (e_q.bitcnt == 4'd7) begin
                e_d.bitcnt = '0;
                if (e_q.live) begin
                    if (!e_q.rd) e_d.wr = '{vld: 1'b1, addr: e_q.addr, data: word[7:0]};
                    e_d.addr = e_q.addr - 12'd1;
                    if (e_q.idx == e_q.lim) begin
                        e_d.live = 1'b0;
                        e_d.oe   = 1'b0;
                        e_d.tx   = 8'h00;
                    end else begin
                        e_d.idx = e_q.idx + 2'd1;
                        e_d.tx  = e_q.rd ? rd_data : 8'h00;
                    end
                end
            end else begin
                e_d.bitcnt = e_q.bitcnt + 4'd1;
            end
        end else if (fall && e_q.ph == PH_DATA && e_q.rd && e_q.live) begin
            e_d.dout = e_q.tx[7];
            e_d.tx   = {e_q.tx[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{ph: PH_CMD, default: '0};
        else        e_q <= e_d;
    end

    assign wr_req = e_q.wr;

    spireg_bank #(.NUM_REGS(NUM_REGS), .REG_BASE(REG_BASE), .REG_INIT(REG_INIT)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_req),
        .rd_addr_i  (look_addr),
        .stat0_i    (stat0_i),
        .stat1_i    (stat1_i),
        .rd_data_o  (rd_data),
        .sdo_en_o   (sdo_en),
        .upd_pend_o (upd_pend),
        .act_o      (act_regs_o)
    );

    assign sdio_o    = e_q.dout;
    assign sdo_o     = e_q.dout;
    assign sdio_oe_o = e_q.oe & ~sdo_en;
    assign sdo_oe_o  = e_q.oe & sdo_en;
endmodule

// File: rtl/spireg_chk.sv
module spireg_chk
    import spireg_pkg::*;
#(
    parameter int                    NUM_REGS = 8,
    parameter logic [NUM_REGS*8-1:0] REG_INIT = {NUM_REGS{8'hA5}}
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n_i,
    input logic                  sdio_oe_o,
    input logic                  sdo_oe_o,
    input logic [NUM_REGS*8-1:0] act_regs_o,
    input logic                  upd_pend,
    input wr_req_t               wr_req
);
    logic soft_rst_wr;
    assign soft_rst_wr = wr_req.vld && (wr_req.addr == CFG_ADDR) && wr_req.data[5];

    a_r6_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe_o && sdo_oe_o));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3))
        |-> !(sdio_oe_o || sdo_oe_o));

    a_r4_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pend |=> !upd_pend);

    a_r3_active_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_regs_o) |-> ($past(upd_pend) || $past(soft_rst_wr)));

    a_r7_soft_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_wr |=> (act_regs_o == REG_INIT));
endmodule

bind spi_shadow_regport spireg_chk #(.NUM_REGS(NUM_REGS), .REG_INIT(REG_INIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (cs_n_i),
    .sdio_oe_o  (sdio_oe_o),
    .sdo_oe_o   (sdo_oe_o),
    .act_regs_o (act_regs_o),
    .upd_pend   (upd_pend),
    .wr_req     (wr_req)
);

// File: tb/sim_spi_shadow_regport.sv
module sim_spi_shadow_regport;
    localparam int H = 8;
    localparam int NR = 8;
    localparam logic [11:0] BASE = 12'h010;
    localparam logic [NR*8-1:0] INIT = {NR{8'hA5}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_i = 1'b0, cs_n_i = 1'b1, sdio_i = 1'b0;
    logic sdio_o, sdio_oe_o, sdo_o, sdo_oe_o;
    logic [7:0] stat0_i = 8'h00, stat1_i = 8'h00;
    logic [NR*8-1:0] act_regs_o;

    always #4 clk = ~clk;

    spi_shadow_regport u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .cs_n_i(cs_n_i), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
        .stat0_i(stat0_i), .stat1_i(stat1_i), .act_regs_o(act_regs_o)
    );

    int nchk = 0, nbad = 0;
    bit done = 0;
    logic [7:0] stg_m [NR];
    logic [7:0] act_m [NR];
    logic sdo_en_m = 1'b0, rb_m = 1'b0;
    int oe_bad = 0;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [NR*8-1:0] act_flat();
        logic [NR*8-1:0] f;
        for (int i = 0; i < NR; i++) f[8*i +: 8] = act_m[i];
        return f;
    endfunction

    function automatic bit in_win(input logic [11:0] a);
        return (a >= BASE) && (a < BASE + 12'(NR));
    endfunction

    task automatic model_defaults();
        for (int i = 0; i < NR; i++) begin
            stg_m[i] = INIT[8*i +: 8];
            act_m[i] = INIT[8*i +: 8];
        end
        sdo_en_m = 1'b0;
        rb_m = 1'b0;
    endtask

    task automatic model_write(input logic [11:0] a, input logic [7:0] v);
        if (a == 12'h000) begin
            if (v[5]) model_defaults();
            else sdo_en_m = v[7];
        end else if (a == 12'h004) rb_m = v[0];
        else if (a == 12'h234) begin
            if (v[0]) for (int i = 0; i < NR; i++) act_m[i] = stg_m[i];
        end else if (in_win(a)) stg_m[a - BASE] = v;
    endtask

    function automatic logic [7:0] exp_byte(input logic [11:0] a);
        if (a == 12'h000) return {sdo_en_m, 7'b0};
        if (a == 12'h004) return {7'b0, rb_m};
        if (a == 12'h22C) return stat0_i;
        if (a == 12'h22D) return stat1_i;
        if (a == 12'h234) return 8'h00;
        if (in_win(a)) return rb_m ? stg_m[a - BASE] : act_m[a - BASE];
        return 8'h00;
    endfunction

    task automatic xfer(input logic [15:0] ins, input logic [23:0] wd, input int nbits,
                        output logic [23:0] rdat);
        int live;
        live = (ins[14:13] == 2'b11) ? 3 : int'(ins[14:13]) + 1;
        rdat = '0;
        @(negedge clk) cs_n_i = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdio_i = (i < 16) ? ins[15 - i] : ((i - 16 < 24) ? wd[23 - (i - 16)] : 1'b0);
            repeat (H - 1) @(negedge clk);
            if (i >= 16 && i - 16 < 24 && ins[15] && (i - 16) / 8 < live) begin
                rdat[23 - (i - 16)] = sdo_en_m ? sdo_o : sdio_o;
                if (sdo_en_m ? !(sdo_oe_o && !sdio_oe_o) : !(sdio_oe_o && !sdo_oe_o)) oe_bad++;
            end
            @(negedge clk) sclk_i = 1'b1;
            repeat (H) @(negedge clk);
            sclk_i = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n_i = 1'b1;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input int n, input logic [23:0] d);
        logic [23:0] dummy;
        xfer({1'b0, 2'(n - 1), 1'b0, a}, d, 16 + 8 * n, dummy);
        for (int k = 0; k < n; k++) model_write(a - 12'(k), d[23 - 8 * k -: 8]);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input int n);
        logic [23:0] got, exp;
        exp = '0;
        for (int k = 0; k < n; k++) exp[23 - 8 * k -: 8] = exp_byte(a - 12'(k));
        oe_bad = 0;
        xfer({1'b1, 2'(n - 1), 1'b0, a}, 24'h0, 16 + 8 * n, got);
        check(req, {40'h0, got}, {40'h0, exp});
        check({req, "/R6 pin enable"}, 64'(oe_bad), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        logic [23:0] dummy;
        int unsigned seed;
        seed = $urandom(32'd2024);
        model_defaults();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R7: reset state
        check("R7 reset active", 64'(act_regs_o), 64'(INIT));
        check("R10 no drive idle", {62'h0, sdio_oe_o, sdo_oe_o}, 64'h0);
        rd_chk("R7 cfg reset", 12'h000, 1);

        // R3: staged write leaves outputs
        wr(12'h012, 3, 24'h112233);
        check("R3 active held", 64'(act_regs_o), 64'(act_flat()));
        rd_chk("R5 read active", 12'h012, 3);
        wr(12'h004, 1, 24'h010000);
        rd_chk("R5 read staged", 12'h012, 3);

        // R4: commit
        wr(12'h234, 1, 24'h010000);
        check("R4 commit", 64'(act_regs_o), 64'(act_flat()));
        rd_chk("R4 commit bit reads 0", 12'h234, 1);

        // R8: live status, descending pair, writes ignored
        stat0_i = 8'h3C; stat1_i = 8'hC5;
        rd_chk("R8 status pair R2", 12'h22D, 2);
        wr(12'h22C, 1, 24'hFF0000);
        stat0_i = 8'h81;
        rd_chk("R8 status after write", 12'h22C, 1);

        // R11: unmapped
        rd_chk("R11 unmapped", 12'h100, 2);

        // R6: 4-wire mode then back
        wr(12'h000, 1, 24'h800000);
        rd_chk("R6 4-wire read", 12'h017, 3);
        wr(12'h000, 1, 24'h000000);
        rd_chk("R6 3-wire read", 12'h011, 2);

        // R1: count field 3 as three bytes, bit 12 ignored, extra byte dropped
        xfer({1'b0, 2'b11, 1'b1, 12'h017}, 24'hA1B2C3, 16 + 32, dummy);
        model_write(12'h017, 8'hA1); model_write(12'h016, 8'hB2); model_write(12'h015, 8'hC3);
        rd_chk("R1 count field 3", 12'h017, 3);
        rd_chk("R1 byte past count untouched", 12'h014, 1);

        // R9: bytes beyond the count
        xfer({1'b0, 2'b00, 1'b0, 12'h012}, 24'h5AC300, 16 + 16, dummy);
        model_write(12'h012, 8'h5A);
        rd_chk("R9 extra byte dropped", 12'h012, 2);

        // R10: partial byte discarded, next transfer starts fresh
        xfer({1'b0, 2'b00, 1'b0, 12'h013}, 24'hFF0000, 16 + 4, dummy);
        rd_chk("R10 partial discarded", 12'h013, 1);
        check("R10 outputs quiet", {62'h0, sdio_oe_o, sdo_oe_o}, 64'h0);

        // Random traffic R2 R3 R4 R5
        for (int it = 0; it < 24; it++) begin
            logic [11:0] a;
            int n;
            a = BASE + 12'($urandom_range(0, 9));
            n = $urandom_range(1, 3);
            wr(a, n, 24'($urandom));
            check("R3 random hold", 64'(act_regs_o), 64'(act_flat()));
            if ($urandom_range(0, 2) == 0) begin
                wr(12'h234, 1, 24'h010000);
                check("R4 random commit", 64'(act_regs_o), 64'(act_flat()));
            end
            wr(12'h004, 1, {7'b0, 1'($urandom_range(0, 1)), 16'h0});
            rd_chk("R2 R5 random read", BASE + 12'($urandom_range(0, 9)), $urandom_range(1, 3));
        end

        // R7: soft reset
        wr(12'h234, 1, 24'h010000);
        wr(12'h000, 1, 24'hA00000);
        check("R7 soft reset active", 64'(act_regs_o), 64'(INIT));
        rd_chk("R7 soft reset cfg", 12'h000, 1);
        rd_chk("R7 soft reset rbk", 12'h004, 1);
        rd_chk("R7 soft reset window", 12'h013, 3);

        done = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule